// File: doc/BRIEF.md
# Packed Float to Unsigned 64-bit Converter

This block turns up to eight IEEE-754 single-precision values into unsigned 64-bit integers in one pass. A 256-bit source vector holds the 32-bit elements. Element j becomes 64-bit destination element j of a 512-bit result. A vector-length select sets how many lanes are active. All destination bits beyond the active lanes are cleared.

Each lane writes its conversion when its mask bit is set or when masking is off. A lane that is not written either keeps the previous destination value (merge) or becomes zero (zero mode). When the source is in memory, a broadcast option feeds element 0 to every lane. The rounding mode comes from an embedded field, but only for a full-width register operation that enables it. Otherwise the global field is used.

Values that cannot be represented return all ones and raise an invalid flag. Inexact conversions raise a precision flag. A reserved specifier that is not all ones raises a fault and leaves the destination as it was. The outputs are registered and appear one cycle after an input strobe.

Top module: `fcvt_u64_vec`

## Requirements
- R1: `vlen_sel` sets the active lane count: 00 gives 2 lanes (128 bits), 01 gives 4 lanes (256 bits), and 10 or 11 gives 8 lanes (512 bits). Result bits above the active lanes are always zero, in merge mode as well. Source bits [32j+31:32j] convert into result bits [64j+63:64j].
- R2: Rounding encoding is 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero. `emb_rc` is used only when `vlen_sel[1]` is 1, `src_is_reg` is 1 and `emb_rc_en` is 1. In every other case `glb_rc` is used.
- R3: A representable lane holds the source value rounded to an integer by the selected mode.
- R4: A lane is invalid if its input is NaN or an infinity, if it rounds to 2^64 or more, or if it is negative and rounds to -1 or below. An invalid lane returns 0xFFFF_FFFF_FFFF_FFFF and sets `flag_inv`. An invalid lane does not set `flag_prec`.
- R5: A valid lane whose result differs from its input sets `flag_prec`. A negative input that rounds to zero returns 0. Negative zero returns 0 exactly. Denormals return 0, or 1 when the mode rounds them up.
- R6: An active lane is written when `mask_off` is 1 or when its bit of `lane_mask` is 1. An unwritten active lane keeps `old_dst` when `zero_mode` is 0 and becomes zero when `zero_mode` is 1.
- R7: When `bcast` is 1 and `src_is_reg` is 0, every active lane converts source element 0. When `src_is_reg` is 1, `bcast` has no effect.
- R8: When `vspec` is not 4'b1111, `fault_ud` is 1, the result equals `old_dst`, and both flags are 0.
- R9: The flags are the OR of lane conditions over lanes that are both active and written. Inactive or unwritten lanes never raise a flag.
- R10: After reset, all outputs are zero. An `in_valid` strobe updates `result`, the flags and `fault_ud` at the next clock edge and pulses `out_valid` for one cycle. Without a strobe, the outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation strobe |
| src_vec | input | 256 | Packed single-precision source elements |
| vlen_sel | input | 2 | Vector length select |
| lane_mask | input | 8 | Per-lane write mask |
| zero_mode | input | 1 | 1 = zero unwritten lanes, 0 = merge |
| mask_off | input | 1 | 1 = write all active lanes regardless of mask |
| bcast | input | 1 | Broadcast element 0 (memory source only) |
| src_is_reg | input | 1 | Source is a register operand |
| emb_rc_en | input | 1 | Enable embedded rounding field |
| emb_rc | input | 2 | Embedded rounding mode |
| glb_rc | input | 2 | Global rounding mode |
| old_dst | input | 512 | Previous destination value |
| vspec | input | 4 | Reserved specifier, must be 4'b1111 |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | 512 | Packed unsigned 64-bit results |
| flag_inv | output | 1 | Invalid condition seen in a written lane |
| flag_prec | output | 1 | Inexact condition seen in a written lane |
| fault_ud | output | 1 | Reserved specifier fault |

## Verification
The assertions take every input to be stable and known during any cycle in which `in_valid` is high. They also assume `old_dst` is sampled together with the strobe, so that the merge and fault checks can compare against the previous cycle's value. The stimulus drives all inputs on the falling edge, raises `in_valid` for exactly one cycle per operation, and holds the operands until the result has been checked. Every `vspec` value, including the fault codes, is therefore seen only in a cycle with a well-defined strobe.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;

  localparam int FW = 32;
  localparam int QW = 64;
  localparam int SPEC_W = 4;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  typedef enum logic [1:0] {
    VL_128 = 2'b00,
    VL_256 = 2'b01,
    VL_512 = 2'b10,
    VL_ALT = 2'b11
  } vlen_e;

  typedef struct packed {
    logic [QW-1:0] val;
    logic          inv;
    logic          inx;
  } conv_t;

  // Decide whether the truncated magnitude is bumped by one.
  function automatic logic round_up(rmode_e rm, logic neg, logic lsb,
                                    logic g, logic st);
    logic inc;
    case (rm)
      RM_NEAR: inc = g & (st | lsb);
      RM_DOWN: inc = neg & (g | st);
      RM_UP:   inc = ~neg & (g | st);
      default: inc = 1'b0;
    endcase
    return inc;
  endfunction

  // Single-precision to unsigned 64-bit conversion of one element.
  function automatic conv_t f32_to_u64(logic [FW-1:0] f, rmode_e rm);
    conv_t       r;
    logic        neg;
    logic [7:0]  e;
    logic [23:0] sig;
    logic [8:0]  expn;
    logic [8:0]  sh;
    logic [87:0] ext;
    logic [23:0] ipart;
    logic        g;
    logic        st;
    logic [24:0] mag;
    r     = '0;
    neg   = f[31];
    e     = f[30:23];
    sig   = {|e, f[22:0]};
    expn  = (e == 8'd0) ? 9'd1 : {1'b0, e};
    sh    = '0;
    ext   = '0;
    ipart = '0;
    g     = 1'b0;
    st    = 1'b0;
    mag   = '0;
    if (e == 8'hFF) begin
      r.val = '1;
      r.inv = 1'b1;
    end else if (expn >= 9'd150) begin
      // integer-valued input: left shift, exact
      sh = expn - 9'd150;
      if (neg || sh > 9'd40) begin
        r.val = '1;
        r.inv = 1'b1;
      end else begin
        r.val = QW'(sig) << sh;
      end
    end else begin
      // fractional bits present: right shift with guard and sticky
      sh = 9'd150 - expn;
      if (sh >= 9'd88) begin
        st = |sig;
      end else begin
        ext   = {sig, 64'd0} >> sh;
        ipart = ext[87:64];
        g     = ext[63];
        st    = |ext[62:0];
      end
      mag = {1'b0, ipart} + 25'(round_up(rm, neg, ipart[0], g, st));
      if (neg && mag != 25'd0) begin
        r.val = '1;
        r.inv = 1'b1;
      end else begin
        r.val = neg ? '0 : QW'(mag);
        r.inx = g | st;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/fcvt_ctrl.sv
module fcvt_ctrl
  import fcvt_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic [1:0]        vlen_sel,
  input  logic              src_is_reg,
  input  logic              emb_rc_en,
  input  logic [1:0]        emb_rc,
  input  logic [1:0]        glb_rc,
  input  logic [SPEC_W-1:0] vspec,
  output logic [LANES-1:0]  lane_act,
  output rmode_e            rm_eff,
  output logic              use_emb,
  output logic              ud_fault
);

  localparam int CNT_W = $clog2(LANES + 1);

  logic [CNT_W-1:0] act_cnt;

  always_comb begin
    case (vlen_e'(vlen_sel))
      VL_128:  act_cnt = CNT_W'(LANES / 4);
      VL_256:  act_cnt = CNT_W'(LANES / 2);
      default: act_cnt = CNT_W'(LANES);
    endcase
  end

  for (genvar j = 0; j < LANES; j++) begin : g_act
    assign lane_act[j] = (CNT_W'(j) < act_cnt);
  end

  assign use_emb  = vlen_sel[1] & src_is_reg & emb_rc_en;
  assign rm_eff   = use_emb ? rmode_e'(emb_rc) : rmode_e'(glb_rc);
  assign ud_fault = (vspec != {SPEC_W{1'b1}});

endmodule

// File: rtl/fcvt_lane.sv
module fcvt_lane
  import fcvt_pkg::*;
(
  input  logic [FW-1:0] elem,
  input  rmode_e        rm,
  input  logic          active,
  input  logic          wr_en,
  input  logic          zero_mode,
  input  logic [QW-1:0] old_q,
  output logic [QW-1:0] lane_q,
  output logic          lane_inv,
  output logic          lane_inx
);

  conv_t cv;
  logic  commit;

  assign cv     = f32_to_u64(elem, rm);
  assign commit = active & wr_en;

  always_comb begin
    if (!active)        lane_q = '0;
    else if (wr_en)     lane_q = cv.val;
    else if (zero_mode) lane_q = '0;
    else                lane_q = old_q;
  end

  assign lane_inv = commit & cv.inv;
  assign lane_inx = commit & cv.inx;

endmodule

// File: rtl/fcvt_u64_vec.sv
module fcvt_u64_vec
  import fcvt_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [LANES*FW-1:0]   src_vec,
  input  logic [1:0]            vlen_sel,
  input  logic [LANES-1:0]      lane_mask,
  input  logic                  zero_mode,
  input  logic                  mask_off,
  input  logic                  bcast,
  input  logic                  src_is_reg,
  input  logic                  emb_rc_en,
  input  logic [1:0]            emb_rc,
  input  logic [1:0]            glb_rc,
  input  logic [LANES*QW-1:0]   old_dst,
  input  logic [SPEC_W-1:0]     vspec,
  output logic                  out_valid,
  output logic [LANES*QW-1:0]   result,
  output logic                  flag_inv,
  output logic                  flag_prec,
  output logic                  fault_ud
);

  localparam int DST_W = LANES * QW;
  localparam int QTR_W = DST_W / 4;

  logic [LANES-1:0] lane_act;
  rmode_e           rm_eff;
  logic             use_emb;
  logic             ud_fault;
  logic             bcast_sel;
  logic [DST_W-1:0] lane_res;
  logic [LANES-1:0] lane_inv_vec;
  logic [LANES-1:0] lane_inx_vec;

  fcvt_ctrl #(.LANES(LANES)) u_ctrl (
    .vlen_sel  (vlen_sel),
    .src_is_reg(src_is_reg),
    .emb_rc_en (emb_rc_en),
    .emb_rc    (emb_rc),
    .glb_rc    (glb_rc),
    .vspec     (vspec),
    .lane_act  (lane_act),
    .rm_eff    (rm_eff),
    .use_emb   (use_emb),
    .ud_fault  (ud_fault)
  );

  assign bcast_sel = bcast & ~src_is_reg;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [FW-1:0] elem;
    assign elem = bcast_sel ? src_vec[FW-1:0] : src_vec[j*FW +: FW];

    fcvt_lane u_lane (
      .elem     (elem),
      .rm       (rm_eff),
      .active   (lane_act[j]),
      .wr_en    (mask_off | lane_mask[j]),
      .zero_mode(zero_mode),
      .old_q    (old_dst[j*QW +: QW]),
      .lane_q   (lane_res[j*QW +: QW]),
      .lane_inv (lane_inv_vec[j]),
      .lane_inx (lane_inx_vec[j])
    );

    // R6
    zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !ud_fault && !mask_off && zero_mode && !lane_mask[j]
      |=> result[j*QW +: QW] == '0);

    // R6
    merge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !ud_fault && !mask_off && !zero_mode && !lane_mask[j] && lane_act[j]
      |=> result[j*QW +: QW] == $past(old_dst[j*QW +: QW]));

    // R4
    inv_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !ud_fault && lane_inv_vec[j]
      |=> result[j*QW +: QW] == '1 && flag_inv);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flag_inv  <= 1'b0;
      flag_prec <= 1'b0;
      fault_ud  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        fault_ud  <= ud_fault;
        result    <= ud_fault ? old_dst : lane_res;
        flag_inv  <= ~ud_fault & (|lane_inv_vec);
        flag_prec <= ~ud_fault & (|lane_inx_vec);
      end
    end
  end

  // R10
  strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(result) && $stable(flag_inv));

  // R8
  fault_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && vspec != {SPEC_W{1'b1}}
    |=> fault_ud && result == $past(old_dst) && !flag_inv && !flag_prec);

  // R1
  upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !ud_fault && vlen_sel == 2'b00
    |=> result[DST_W-1:QTR_W] == '0);

  // R9
  quiet_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !ud_fault && (lane_act & (lane_mask | {LANES{mask_off}})) == '0
    |=> !flag_inv && !flag_prec);

endmodule

// File: tb/fcvt_u64_vec_test.sv
module fcvt_u64_vec_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [255:0] src_vec;
  logic [1:0]   vlen_sel;
  logic [7:0]   lane_mask;
  logic         zero_mode, mask_off, bcast, src_is_reg, emb_rc_en;
  logic [1:0]   emb_rc, glb_rc;
  logic [511:0] old_dst;
  logic [3:0]   vspec;
  logic         out_valid;
  logic [511:0] result;
  logic         flag_inv, flag_prec, fault_ud;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  fcvt_u64_vec uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
    .vlen_sel(vlen_sel), .lane_mask(lane_mask), .zero_mode(zero_mode),
    .mask_off(mask_off), .bcast(bcast), .src_is_reg(src_is_reg),
    .emb_rc_en(emb_rc_en), .emb_rc(emb_rc), .glb_rc(glb_rc),
    .old_dst(old_dst), .vspec(vspec), .out_valid(out_valid),
    .result(result), .flag_inv(flag_inv), .flag_prec(flag_prec),
    .fault_ud(fault_ud)
  );

  localparam logic [31:0] SPECIALS [24] = '{
    32'h00000000, 32'h80000000, 32'h3F800000, 32'h3FC00000,
    32'h40200000, 32'hBF000000, 32'hBF800000, 32'hBFC00000,
    32'h3F000000, 32'h00000001, 32'h80000001, 32'h7F800000,
    32'hFF800000, 32'h7FC00000, 32'h5F7FFFFF, 32'h5F800000,
    32'h5F000000, 32'h4B7FFFFF, 32'h3F7FFFFF, 32'hBF7FFFFF,
    32'h4EFFFFFF, 32'hBECCCCCD, 32'h3F400000, 32'h40600000
  };

  function automatic real pow2(int k);
    real p = 1.0;
    if (k >= 0) for (int i = 0; i < k; i++) p = p * 2.0;
    else for (int i = 0; i < -k; i++) p = p / 2.0;
    return p;
  endfunction

  // Arithmetic reference: value as a real, rounded by the mode.
  task automatic ref_conv(input logic [31:0] f, input logic [1:0] rm,
                          output logic [63:0] v, output logic inv, output logic inx);
    int  ex;
    int  sg;
    real x, rr, fl, d;
    v = '0; inv = 1'b0; inx = 1'b0;
    ex = int'(f[30:23]);
    if (ex == 255) begin
      v = '1; inv = 1'b1;
      return;
    end
    sg = int'(f[22:0]) + ((ex == 0) ? 0 : 8388608);
    x  = real'(sg) * pow2(((ex == 0) ? 1 : ex) - 150);
    if (f[31]) x = -x;
    case (rm)
      2'b00: begin
        fl = $floor(x);
        d  = x - fl;
        rr = (d > 0.5 || (d == 0.5 && $floor(fl / 2.0) * 2.0 != fl)) ? fl + 1.0 : fl;
      end
      2'b01: rr = $floor(x);
      2'b10: rr = $ceil(x);
      default: rr = (x < 0.0) ? $ceil(x) : $floor(x);
    endcase
    if (rr <= -1.0 || rr >= pow2(64)) begin
      v = '1; inv = 1'b1;
    end else begin
      inx = (rr != x);
      if (rr >= pow2(63)) v = 64'(longint'(rr - pow2(63))) | 64'h8000_0000_0000_0000;
      else v = 64'(longint'(rr));
    end
  endtask

  task automatic model(output logic [511:0] r, output logic inv, output logic prec,
                       output logic ud);
    int          cnt;
    logic [1:0]  rm;
    logic [31:0] el;
    logic [63:0] v;
    logic        li, lx;
    r = '0; inv = 1'b0; prec = 1'b0;
    ud = (vspec != 4'hF);
    if (ud) begin
      r = old_dst;
      return;
    end
    cnt = (vlen_sel == 2'b00) ? 2 : (vlen_sel == 2'b01) ? 4 : 8;
    rm  = (vlen_sel[1] && src_is_reg && emb_rc_en) ? emb_rc : glb_rc;
    for (int j = 0; j < cnt; j++) begin
      if (mask_off || lane_mask[j]) begin
        el = (bcast && !src_is_reg) ? src_vec[31:0] : src_vec[j*32 +: 32];
        ref_conv(el, rm, v, li, lx);
        r[j*64 +: 64] = v;
        inv  = inv | li;
        prec = prec | lx;
      end else if (!zero_mode) begin
        r[j*64 +: 64] = old_dst[j*64 +: 64];
      end
    end
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic run_op(input string tag_in, input bit hold);
    logic [511:0] er;
    logic         ei, ep, eu;
    string        tag;
    model(er, ei, ep, eu);
    tag = tag_in;
    if (tag == "") tag = ei ? "R4" : (ep ? "R5" : "R3");
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(tag, "result", result, er);
    chk(tag, "flag_inv", 512'(flag_inv), 512'(ei));
    chk(tag, "flag_prec", 512'(flag_prec), 512'(ep));
    chk(tag, "fault_ud", 512'(fault_ud), 512'(eu));
    chk("R10", "out_valid pulse", 512'(out_valid), 512'd1);
    if (hold) begin
      @(posedge clk);
      @(negedge clk);
      chk("R10", "out_valid idle", 512'(out_valid), 512'd0);
      chk("R10", "result hold", result, er);
    end
  endtask

  function automatic logic [31:0] rnd_float();
    return {1'($urandom), 8'(105 + $urandom % 90), 23'($urandom)};
  endfunction

  task automatic fill_src(input bit raw);
    for (int j = 0; j < 8; j++) src_vec[j*32 +: 32] = raw ? 32'($urandom) : rnd_float();
  endtask

  task automatic fill_old();
    for (int j = 0; j < 16; j++) old_dst[j*32 +: 32] = 32'($urandom);
  endtask

  task automatic defaults();
    src_vec = '0; vlen_sel = 2'b10; lane_mask = '0; zero_mode = 1'b0;
    mask_off = 1'b1; bcast = 1'b0; src_is_reg = 1'b1; emb_rc_en = 1'b0;
    emb_rc = 2'b00; glb_rc = 2'b00; old_dst = '0; vspec = 4'hF;
  endtask

  initial begin
    #1000000;
    n_err++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    rst_n = 1'b0; in_valid = 1'b0;
    defaults();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk("R10", "reset result", result, '0);
    chk("R10", "reset flags", 512'({flag_inv, flag_prec, fault_ud, out_valid}), '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4 R5: each special value alone in lane 0, every rounding mode
    for (int m = 0; m < 4; m++) begin
      for (int i = 0; i < 24; i++) begin
        defaults();
        glb_rc = 2'(m);
        src_vec[31:0] = SPECIALS[i];
        run_op("", (i % 6) == 0);
      end
    end

    // R3: random finite vectors, random modes
    for (int i = 0; i < 300; i++) begin
      defaults();
      fill_src(1'b0);
      glb_rc = 2'($urandom);
      run_op("R3", 1'b0);
    end

    // R6: every mask, merge and zero
    for (int z = 0; z < 2; z++) begin
      for (int m = 0; m < 256; m++) begin
        defaults();
        fill_src(1'b0); fill_old();
        mask_off = 1'b0; zero_mode = z[0]; lane_mask = 8'(m);
        glb_rc = 2'($urandom);
        run_op("R6", 1'b0);
      end
    end
    defaults(); fill_src(1'b0); fill_old(); lane_mask = 8'h00; mask_off = 1'b1;
    run_op("R6", 1'b0);

    // R1: lengths with merge and zero, upper bits cleared
    for (int v = 0; v < 4; v++) begin
      for (int i = 0; i < 12; i++) begin
        defaults();
        fill_src(1'b0); old_dst = '1;
        vlen_sel = 2'(v); mask_off = 1'($urandom);
        lane_mask = 8'($urandom); zero_mode = 1'(i % 2);
        run_op("R1", 1'b0);
      end
    end

    // R9: NaN in inactive or unwritten lanes raises nothing
    defaults(); src_vec = {32'h7FC00000, 32'h3FC00000, {6{32'h3F800000}}};
    vlen_sel = 2'b00;
    run_op("R9", 1'b0);
    defaults(); src_vec = {32'h3F800000, 32'h7FC00000, 32'h3FC00000, {5{32'h3F800000}}};
    mask_off = 1'b0; lane_mask = 8'b1011_1111; zero_mode = 1'b1;
    run_op("R9", 1'b0);
    defaults(); src_vec = {8{32'h7F800000}}; mask_off = 1'b0; lane_mask = 8'h00;
    run_op("R9", 1'b0);

    // R2: rounding-source sweep on 2.5 / -0.5 lanes
    for (int v = 0; v < 4; v++)
      for (int rg = 0; rg < 2; rg++)
        for (int en = 0; en < 2; en++)
          for (int er = 0; er < 4; er++)
            for (int gr = 0; gr < 4; gr++) begin
              defaults();
              for (int j = 0; j < 8; j++) src_vec[j*32 +: 32] = j[0] ? 32'hBF000000 : 32'h40200000;
              vlen_sel = 2'(v); src_is_reg = rg[0]; emb_rc_en = en[0];
              emb_rc = 2'(er); glb_rc = 2'(gr);
              run_op("R2", 1'b0);
            end

    // R7: broadcast with memory and register sources
    for (int i = 0; i < 40; i++) begin
      defaults();
      fill_src(1'b0); fill_old();
      bcast = 1'b1; src_is_reg = 1'(i % 2); vlen_sel = 2'(i / 2);
      mask_off = 1'(i / 20); lane_mask = 8'($urandom);
      run_op("R7", 1'b0);
    end

    // R8: every bad specifier
    for (int s = 0; s < 15; s++) begin
      defaults();
      fill_src(1'b1); fill_old();
      vspec = 4'(s); glb_rc = 2'($urandom);
      vlen_sel = 2'($urandom); mask_off = 1'($urandom); lane_mask = 8'($urandom);
      run_op("R8", 1'b1);
    end

    // R4: raw random bit patterns, includes NaN and huge values
    for (int i = 0; i < 100; i++) begin
      defaults();
      fill_src(1'b1);
      glb_rc = 2'($urandom);
      run_op("R4", 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule